// File: doc/BRIEF.md
# Raster Sync and Window Timing Generator

This block counts pixel-rate clocks along a fixed PAL-style raster of 1024 clocks per line and 312 lines per frame. From that count it produces active-low horizontal sync and active-low vertical/composite sync. It also produces three window flags. The first marks lines that carry picture. The second marks the span in which downstream logic may fetch display memory. The third marks the span, eight clocks later, in which decoded pixels reach the screen. A one-clock line-start pulse and a one-clock frame-start pulse give address logic its reload points.

Two state machines do the decoding. The horizontal machine `raster_hfsm` has the states H_OFF, H_SYNC, H_PORCH, H_FETCH, H_BOTH, H_DRAIN and H_TAIL. It moves:
- H_OFF to H_SYNC when reset is released;
- H_SYNC to H_PORCH at count 75;
- H_PORCH to H_FETCH at 256;
- H_FETCH to H_BOTH at 264;
- H_BOTH to H_DRAIN at 896;
- H_DRAIN to H_TAIL at 904;
- H_TAIL to H_SYNC at 0.

The vertical machine `raster_vfsm` has the states V_OFF, V_SYNC_FULL, V_SYNC_HALF, V_TOP, V_ACTIVE and V_BOTTOM. It moves:
- V_OFF to V_SYNC_FULL when reset is released;
- V_SYNC_FULL to V_SYNC_HALF at line 2, count 0;
- V_SYNC_HALF to V_TOP at count 512 of that line;
- V_TOP to V_ACTIVE at line 38;
- V_ACTIVE to V_BOTTOM at line 294;
- V_BOTTOM to V_SYNC_FULL at line 0.

Every limit is a parameter of the top module. None of them can be changed at run time.

Top module: `raster_timing_gen`

## Requirements
- R1: `h_count` advances by one on every clock while running, from 0 to H_TOTAL-1 (default 1023), then returns to 0.
- R2: `v_count` advances by one in the clock where `h_count` wraps, and after line V_TOTAL-1 (default 311) returns to 0.
- R3: `hsync_n` is 0 exactly while `h_count` is below HSYNC_LEN (default 75), so each low pulse lasts 75 clocks.
- R4: `vsync_n` falls at line 0, count 0, and stays 0 for all of lines 0 and 1.
- R5: `vsync_n` returns to 1 on line VS_END_LINE (default 2) at count VS_END_H (default 512), giving a low time of 2560 clocks.
- R6: `line_active` is 1 exactly on lines V_ACT_START to V_ACT_START+V_ACT_LINES-1 (default 38 to 293).
- R7: `fetch_win` is 1 exactly when `line_active` is 1 and `h_count` lies from H_ACT_START to H_ACT_START+H_ACT_W-1 (default 256 to 895).
- R8: `pixel_win` is 1 exactly when `line_active` is 1 and `h_count` lies in the fetch span moved PIX_DELAY (default 8) clocks later (default 264 to 903).
- R9: While synchronous reset `rst` is 1, both counts are 0, both syncs are 1, and all flags and pulses are 0. In the first clock after release, the outputs show line 0, count 0, with both syncs at 0.
- R10: `line_start` is 1 exactly when `h_count` is 0. `frame_start` is 1 exactly when both counts are 0, so consecutive line starts are H_TOTAL clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | pixel-rate clock |
| rst | input | 1 | synchronous reset, active high |
| h_count | output | $clog2(H_TOTAL) | clock position within the line |
| v_count | output | $clog2(V_TOTAL) | line number within the frame |
| hsync_n | output | 1 | horizontal sync, active low |
| vsync_n | output | 1 | vertical/composite sync, active low |
| line_start | output | 1 | one-clock pulse at count 0 |
| frame_start | output | 1 | one-clock pulse at line 0, count 0 |
| line_active | output | 1 | current line carries picture |
| fetch_win | output | 1 | memory fetch span |
| pixel_win | output | 1 | displayed pixel span |

## Verification
Two configurations run at the same time, and a model built from the requirements predicts every output on every clock.

The default raster runs for about 44 lines. This is long enough to cover both sync pulses, the mid-line vsync release and the start of the active lines. It also separates an off-by-one at any window edge, and a pixel window that is not delayed from one that is.

A shrunken raster of 64 clocks by 20 lines runs for many whole frames. It exercises the frame wrap, the end of the active lines and repeated frame-start pulses, which the default raster is too long to reach.

Measured edge-to-edge distances on the default raster separate a wrong sync width from a wrong sync position.

// File: rtl/raster_pkg.sv
package raster_pkg;

    typedef enum logic [2:0] {
        H_OFF,
        H_SYNC,
        H_PORCH,
        H_FETCH,
        H_BOTH,
        H_DRAIN,
        H_TAIL
    } hphase_t;

    typedef enum logic [2:0] {
        V_OFF,
        V_SYNC_FULL,
        V_SYNC_HALF,
        V_TOP,
        V_ACTIVE,
        V_BOTTOM
    } vphase_t;

endpackage

// File: rtl/raster_counter.sv
module raster_counter #(
    parameter int LIMIT = 1024,
    localparam int W = $clog2(LIMIT)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] cnt_n,
    output logic         wrap
);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    assign wrap = step && (cnt_q == LAST);

    always_comb begin
        if (!step)
            cnt_n = cnt_q;
        else if (cnt_q == LAST)
            cnt_n = '0;
        else
            cnt_n = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else
            cnt_q <= cnt_n;
    end

    p_count_bound_r1: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

endmodule

// File: rtl/raster_hfsm.sv
module raster_hfsm
    import raster_pkg::*;
#(
    parameter int H_TOTAL     = 1024,
    parameter int HSYNC_LEN   = 75,
    parameter int H_ACT_START = 256,
    parameter int H_ACT_W     = 640,
    parameter int PIX_DELAY   = 8,
    localparam int W = $clog2(H_TOTAL)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] h_q,
    input  logic [W-1:0] h_n,
    output logic         hsync_n,
    output logic         fetch_h,
    output logic         pix_h,
    output logic         sol
);
    localparam logic [W-1:0] E_SYNC  = W'(HSYNC_LEN);
    localparam logic [W-1:0] E_FETCH = W'(H_ACT_START);
    localparam logic [W-1:0] E_BOTH  = W'(H_ACT_START + PIX_DELAY);
    localparam logic [W-1:0] E_DRAIN = W'(H_ACT_START + H_ACT_W);
    localparam logic [W-1:0] E_TAIL  = W'(H_ACT_START + H_ACT_W + PIX_DELAY);

    hphase_t st_q, st_n;

    always_comb begin
        st_n = st_q;
        unique case (st_q)
            H_OFF:   st_n = H_SYNC;
            H_SYNC:  if (h_n == E_SYNC)  st_n = H_PORCH;
            H_PORCH: if (h_n == E_FETCH) st_n = H_FETCH;
            H_FETCH: if (h_n == E_BOTH)  st_n = H_BOTH;
            H_BOTH:  if (h_n == E_DRAIN) st_n = H_DRAIN;
            H_DRAIN: if (h_n == E_TAIL)  st_n = H_TAIL;
            H_TAIL:  if (h_n == '0)      st_n = H_SYNC;
            default: st_n = H_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= H_OFF;
            sol  <= 1'b0;
        end else begin
            st_q <= st_n;
            sol  <= (h_n == '0);
        end
    end

    always_comb begin
        hsync_n = 1'b1;
        fetch_h = 1'b0;
        pix_h   = 1'b0;
        unique case (st_q)
            H_SYNC:  hsync_n = 1'b0;
            H_FETCH: fetch_h = 1'b1;
            H_BOTH:  begin fetch_h = 1'b1; pix_h = 1'b1; end
            H_DRAIN: pix_h = 1'b1;
            default: ;
        endcase
    end

    p_hsync_fall_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(hsync_n) |-> h_q == '0);
    p_hsync_rise_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(hsync_n) |-> h_q == E_SYNC);
    p_sol_pos_r10: assert property (@(posedge clk) disable iff (rst)
        sol |-> h_q == '0);

endmodule

// File: rtl/raster_vfsm.sv
module raster_vfsm
    import raster_pkg::*;
#(
    parameter int H_TOTAL      = 1024,
    parameter int V_TOTAL      = 312,
    parameter int VS_END_LINE  = 2,
    parameter int VS_END_H     = 512,
    parameter int V_ACT_START  = 38,
    parameter int V_ACT_LINES  = 256,
    localparam int HW = $clog2(H_TOTAL),
    localparam int VW = $clog2(V_TOTAL)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [HW-1:0] h_q,
    input  logic [HW-1:0] h_n,
    input  logic [VW-1:0] v_q,
    input  logic [VW-1:0] v_n,
    output logic          vsync_n,
    output logic          line_act,
    output logic          sof
);
    localparam logic [VW-1:0] L_HALF = VW'(VS_END_LINE);
    localparam logic [HW-1:0] H_HALF = HW'(VS_END_H);
    localparam logic [VW-1:0] L_ACT  = VW'(V_ACT_START);
    localparam logic [VW-1:0] L_BOT  = VW'(V_ACT_START + V_ACT_LINES);

    vphase_t st_q, st_n;
    logic    line_edge;

    assign line_edge = (h_n == '0);

    always_comb begin
        st_n = st_q;
        unique case (st_q)
            V_OFF:       st_n = V_SYNC_FULL;
            V_SYNC_FULL: if (line_edge && v_n == L_HALF) st_n = V_SYNC_HALF;
            V_SYNC_HALF: if (h_n == H_HALF)              st_n = V_TOP;
            V_TOP:       if (line_edge && v_n == L_ACT)  st_n = V_ACTIVE;
            V_ACTIVE:    if (line_edge && v_n == L_BOT)  st_n = V_BOTTOM;
            V_BOTTOM:    if (line_edge && v_n == '0)     st_n = V_SYNC_FULL;
            default:     st_n = V_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= V_OFF;
            sof  <= 1'b0;
        end else begin
            st_q <= st_n;
            sof  <= line_edge && (v_n == '0);
        end
    end

    always_comb begin
        vsync_n  = 1'b1;
        line_act = 1'b0;
        unique case (st_q)
            V_SYNC_FULL: vsync_n  = 1'b0;
            V_SYNC_HALF: vsync_n  = 1'b0;
            V_ACTIVE:    line_act = 1'b1;
            default: ;
        endcase
    end

    p_vsync_fall_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(vsync_n) |-> (v_q == '0 && h_q == '0));
    p_vsync_rise_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(vsync_n) |-> (v_q == L_HALF && h_q == H_HALF));
    p_active_start_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(line_act) |-> (v_q == L_ACT && h_q == '0));

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen #(
    parameter int H_TOTAL     = 1024,
    parameter int HSYNC_LEN   = 75,
    parameter int H_ACT_START = 256,
    parameter int H_ACT_W     = 640,
    parameter int PIX_DELAY   = 8,
    parameter int V_TOTAL     = 312,
    parameter int VS_END_LINE = 2,
    parameter int VS_END_H    = 512,
    parameter int V_ACT_START = 38,
    parameter int V_ACT_LINES = 256
) (
    input  logic                       clk,
    input  logic                       rst,
    output logic [$clog2(H_TOTAL)-1:0] h_count,
    output logic [$clog2(V_TOTAL)-1:0] v_count,
    output logic                       hsync_n,
    output logic                       vsync_n,
    output logic                       line_start,
    output logic                       frame_start,
    output logic                       line_active,
    output logic                       fetch_win,
    output logic                       pixel_win
);
    localparam int HW = $clog2(H_TOTAL);
    localparam int VW = $clog2(V_TOTAL);

    logic          running_q;
    logic [HW-1:0] h_n;
    logic [VW-1:0] v_n;
    logic          h_wrap, v_wrap;
    logic          fetch_h, pix_h;

    always_ff @(posedge clk) begin
        if (rst)
            running_q <= 1'b0;
        else
            running_q <= 1'b1;
    end

    raster_counter #(.LIMIT(H_TOTAL)) u_hcnt (
        .clk(clk), .rst(rst), .step(running_q),
        .cnt_q(h_count), .cnt_n(h_n), .wrap(h_wrap)
    );

    raster_counter #(.LIMIT(V_TOTAL)) u_vcnt (
        .clk(clk), .rst(rst), .step(h_wrap),
        .cnt_q(v_count), .cnt_n(v_n), .wrap(v_wrap)
    );

    raster_hfsm #(
        .H_TOTAL(H_TOTAL), .HSYNC_LEN(HSYNC_LEN), .H_ACT_START(H_ACT_START),
        .H_ACT_W(H_ACT_W), .PIX_DELAY(PIX_DELAY)
    ) u_hfsm (
        .clk(clk), .rst(rst), .h_q(h_count), .h_n(h_n),
        .hsync_n(hsync_n), .fetch_h(fetch_h), .pix_h(pix_h), .sol(line_start)
    );

    raster_vfsm #(
        .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL), .VS_END_LINE(VS_END_LINE),
        .VS_END_H(VS_END_H), .V_ACT_START(V_ACT_START), .V_ACT_LINES(V_ACT_LINES)
    ) u_vfsm (
        .clk(clk), .rst(rst), .h_q(h_count), .h_n(h_n), .v_q(v_count), .v_n(v_n),
        .vsync_n(vsync_n), .line_act(line_active), .sof(frame_start)
    );

    assign fetch_win = fetch_h & line_active;
    assign pixel_win = pix_h & line_active;

    p_line_wrap_r1: assert property (@(posedge clk) disable iff (rst)
        h_wrap |=> h_count == '0);
    p_frame_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        v_wrap |=> (v_count == '0 && frame_start));
    p_fetch_open_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(fetch_win) |-> h_count == HW'(H_ACT_START));
    p_pix_open_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(pixel_win) |-> h_count == HW'(H_ACT_START + PIX_DELAY));
    p_sof_in_sol_r10: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> line_start);

endmodule

// File: tb/sim_raster_timing_gen.sv
module sim_raster_timing_gen;

    typedef struct {
        int ht, hs, ha, hw, d, vt, vsl, vsh, va, vl;
    } cfg_t;

    typedef struct {
        int h, v, hs, vs, la, fw, pw, sol, sof;
    } exp_t;

    localparam int NCYC = 45000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [9:0] h0;  logic [8:0] v0;
    logic hs0, vs0, sl0, sf0, la0, fw0, pw0;
    logic [5:0] h1;  logic [4:0] v1;
    logic hs1, vs1, sl1, sf1, la1, fw1, pw1;

    raster_timing_gen u0 (
        .clk(clk), .rst(rst), .h_count(h0), .v_count(v0),
        .hsync_n(hs0), .vsync_n(vs0), .line_start(sl0), .frame_start(sf0),
        .line_active(la0), .fetch_win(fw0), .pixel_win(pw0)
    );

    raster_timing_gen #(
        .H_TOTAL(64), .HSYNC_LEN(5), .H_ACT_START(16), .H_ACT_W(32), .PIX_DELAY(8),
        .V_TOTAL(20), .VS_END_LINE(2), .VS_END_H(32), .V_ACT_START(4), .V_ACT_LINES(12)
    ) u1 (
        .clk(clk), .rst(rst), .h_count(h1), .v_count(v1),
        .hsync_n(hs1), .vsync_n(vs1), .line_start(sl1), .frame_start(sf1),
        .line_active(la1), .fetch_win(fw1), .pixel_win(pw1)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;
    exp_t q0[$];
    exp_t q1[$];

    function automatic exp_t model(cfg_t c, int h, int v);
        exp_t e;
        e.h   = h;
        e.v   = v;
        e.hs  = (h < c.hs) ? 0 : 1;
        e.vs  = (v < c.vsl || (v == c.vsl && h < c.vsh)) ? 0 : 1;
        e.la  = (v >= c.va && v < c.va + c.vl) ? 1 : 0;
        e.fw  = (e.la == 1 && h >= c.ha && h < c.ha + c.hw) ? 1 : 0;
        e.pw  = (e.la == 1 && h >= c.ha + c.d && h < c.ha + c.hw + c.d) ? 1 : 0;
        e.sol = (h == 0) ? 1 : 0;
        e.sof = (h == 0 && v == 0) ? 1 : 0;
        return e;
    endfunction

    task automatic drive_expect(cfg_t c, int n, bit which);
        int h = 0;
        int v = 0;
        for (int i = 0; i < n; i++) begin
            if (which) q1.push_back(model(c, h, v));
            else       q0.push_back(model(c, h, v));
            h++;
            if (h == c.ht) begin
                h = 0;
                v = (v + 1 == c.vt) ? 0 : v + 1;
            end
        end
    endtask

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic cmp(string who, exp_t e, int h, int v, int hs, int vs,
                       int sl, int sf, int la, int fw, int pw);
        check("R1", {who, " h_count"}, h, e.h);
        check("R2", {who, " v_count"}, v, e.v);
        check("R3", {who, " hsync_n"}, hs, e.hs);
        check("R4/R5", {who, " vsync_n"}, vs, e.vs);
        check("R6", {who, " line_active"}, la, e.la);
        check("R7", {who, " fetch_win"}, fw, e.fw);
        check("R8", {who, " pixel_win"}, pw, e.pw);
        check("R10", {who, " line_start"}, sl, e.sol);
        check("R10", {who, " frame_start"}, sf, e.sof);
    endtask

    initial begin
        cfg_t c0, c1;
        exp_t e;
        int hs_fall = -1, vs_fall = -1, last_sol = -1;
        int prev_hs = 1, prev_vs = 1;
        c0 = '{1024, 75, 256, 640, 8, 312, 2, 512, 38, 256};
        c1 = '{64, 5, 16, 32, 8, 20, 2, 32, 4, 12};
        drive_expect(c0, NCYC, 1'b0);
        drive_expect(c1, NCYC, 1'b1);

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset state
        check("R9", "reset h_count", int'(h0), 0);
        check("R9", "reset v_count", int'(v0), 0);
        check("R9", "reset hsync_n", int'(hs0), 1);
        check("R9", "reset vsync_n", int'(vs0), 1);
        check("R9", "reset flags", int'({sl0, sf0, la0, fw0, pw0}), 0);
        check("R9", "reset small syncs", int'({hs1, vs1}), 3);
        rst = 1'b0;

        for (int i = 0; i < NCYC; i++) begin
            @(negedge clk);
            e = q0.pop_front();
            cmp("u0", e, int'(h0), int'(v0), int'(hs0), int'(vs0), int'(sl0),
                int'(sf0), int'(la0), int'(fw0), int'(pw0));
            e = q1.pop_front();
            cmp("u1", e, int'(h1), int'(v1), int'(hs1), int'(vs1), int'(sl1),
                int'(sf1), int'(la1), int'(fw1), int'(pw1));
            if (i == 0) check("R9", "first clock syncs low", int'({hs0, vs0}), 0);
            // measured pulse widths on the default raster
            if (prev_hs == 1 && hs0 == 1'b0) hs_fall = i;
            if (prev_hs == 0 && hs0 == 1'b1 && hs_fall >= 0)
                check("R3", "hsync low width", i - hs_fall, c0.hs);
            if (prev_vs == 1 && vs0 == 1'b0) vs_fall = i;
            if (prev_vs == 0 && vs0 == 1'b1 && vs_fall >= 0)
                check("R5", "vsync low width", i - vs_fall, c0.vsl * c0.ht + c0.vsh);
            if (sl0) begin
                if (last_sol >= 0) check("R10", "line_start spacing", i - last_sol, c0.ht);
                last_sol = i;
            end
            prev_hs = int'(hs0);
            prev_vs = int'(vs0);
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (NCYC + 1000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule